// File: doc/BRIEF.md
# Complement-Checked Control Register Write Gate

This block sits between an instruction decoder and three critical control registers: a standby control byte, a watchdog mode byte and a memory location setting. The decoder hands it a write strobe, a target select, a data byte, a check byte, and the start address of the instruction that issued the write. The write takes effect only when the check byte is the exact bitwise complement of the data byte.

A check byte that fails the test cancels the write. The block then sends the interrupt sequencer an operand-error request, together with the start address of the offending instruction. No enable input can mask this request. The block holds the faulting address until the sequencer acknowledges it, so the handler can decide whether to skip or restart the instruction.

Top module: `guarded_write_gate`

## Requirements
- R1: A strobed write whose check byte equals the bitwise inverse of its data byte loads the data into the selected register, visible one clock after the strobe.
- R2: A committed write changes only the register named by the select (0 = standby, 1 = watchdog mode, 2 = location); the other two keep their values.
- R3: A strobed write to select 0, 1 or 2 whose check byte is not the exact inverse of the data is discarded, and the target keeps its previous value.
- R4: Each discarded write raises `err_req` for exactly one clock, one clock after the strobe, and no input can suppress it.
- R5: When `err_pend` rises, `err_addr` holds the instruction start address given with the faulting write. While `err_pend` stays set, later faults do not change `err_addr`.
- R6: `err_ack` clears `err_pend` on the next clock. If a new fault arrives in the same cycle as the acknowledge, that fault's address is captured and `err_pend` stays set.
- R7: Select value 3 names no register; a strobe with it changes no register and raises no error, whatever the check byte is.
- R8: Reset loads standby 0x00, watchdog mode 0x70 and location 0x0F (the parameter defaults), and clears `err_req` and `err_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Guarded write request, one cycle |
| wr_sel | input | 2 | Target: 0 standby, 1 watchdog mode, 2 location, 3 none |
| wr_data | input | 8 | Data byte |
| wr_check | input | 8 | Check byte, must equal ~wr_data |
| wr_addr | input | 20 | Start address of the issuing instruction |
| err_ack | input | 1 | Sequencer acknowledge of the pending error |
| stby_q | output | 8 | Standby control register |
| wdog_q | output | 8 | Watchdog mode register |
| loc_q | output | 8 | Location setting register |
| err_req | output | 1 | Operand-error request pulse |
| err_pend | output | 1 | Error awaiting acknowledge |
| err_addr | output | 20 | Start address of the faulting instruction |

## Verification
Each target is written with proper complement pairs, including the all-ones/all-zeros pair. After every write the bench reads all three registers, which shows whether a commit lands only in the selected register. Bad pairs are tried in two forms: a check byte equal to the data byte, and one that differs from the true inverse by a single bit. A comparator that checks only some bits would pass the single-bit case. The unused select is driven with both a good and a bad pair, which separates "ignored" from "faulted". Directed tests cover a second fault while one is pending, an acknowledge that coincides with a new fault, and reset while an error is pending.

// File: rtl/guarded_write_gate.sv
module guarded_write_gate #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20,
  parameter logic [DATA_W-1:0] STBY_RST = 8'h00,
  parameter logic [DATA_W-1:0] WDOG_RST = 8'h70,
  parameter logic [DATA_W-1:0] LOC_RST  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_check,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              err_ack,
  output logic [DATA_W-1:0] stby_q,
  output logic [DATA_W-1:0] wdog_q,
  output logic [DATA_W-1:0] loc_q,
  output logic              err_req,
  output logic              err_pend,
  output logic [ADDR_W-1:0] err_addr
);
  localparam logic [1:0] SEL_STBY = 2'd0;
  localparam logic [1:0] SEL_WDOG = 2'd1;
  localparam logic [1:0] SEL_LOC  = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  wire hit    = wr_stb && (wr_sel != SEL_NONE);
  wire pair_ok = (wr_check == ~wr_data);
  wire commit = hit && pair_ok;
  wire fault  = hit && !pair_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q <= STBY_RST;
      wdog_q <= WDOG_RST;
      loc_q  <= LOC_RST;
    end else if (commit) begin
      if (wr_sel == SEL_STBY) stby_q <= wr_data;
      if (wr_sel == SEL_WDOG) wdog_q <= wr_data;
      if (wr_sel == SEL_LOC)  loc_q  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_req  <= 1'b0;
      err_pend <= 1'b0;
      err_addr <= '0;
    end else begin
      err_req  <= fault;
      err_pend <= fault || (err_pend && !err_ack);
      if (fault && (!err_pend || err_ack)) err_addr <= wr_addr;
    end
  end

  // R1
  wdog_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_sel == SEL_WDOG && wr_check == ~wr_data) |=> wdog_q == $past(wr_data));

  // R3
  stby_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_sel == SEL_STBY && wr_check != ~wr_data) |=> $stable(stby_q));

  // R4
  req_flags_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> err_pend);

  // R5
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pend) |-> err_addr == $past(wr_addr));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ack && !(wr_stb && wr_sel != SEL_NONE && wr_check != ~wr_data)) |=> !err_pend);

  // R7
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_sel == SEL_NONE) |=> (!err_req && $stable(loc_q) && $stable(stby_q) && $stable(wdog_q)));
endmodule

// File: tb/test_guarded_write_gate.sv
module test_guarded_write_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00, wr_check = 8'h00;
  logic [19:0] wr_addr = 20'h0;
  logic err_ack = 1'b0;
  logic [7:0] stby_q, wdog_q, loc_q;
  logic err_req, err_pend;
  logic [19:0] err_addr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  guarded_write_gate i_guarded_write_gate (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_check(wr_check), .wr_addr(wr_addr), .err_ack(err_ack), .stby_q(stby_q),
    .wdog_q(wdog_q), .loc_q(loc_q), .err_req(err_req), .err_pend(err_pend), .err_addr(err_addr));

  // {sel, data, check, exp_stby, exp_wdog, exp_loc, exp_err}
  localparam int NV = 11;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 8'h05, 8'hFA, 8'h05, 8'h70, 8'h0F, 1'b0},
    {2'd1, 8'h33, 8'hCC, 8'h05, 8'h33, 8'h0F, 1'b0},
    {2'd2, 8'hA5, 8'h5A, 8'h05, 8'h33, 8'hA5, 1'b0},
    {2'd0, 8'h77, 8'h77, 8'h05, 8'h33, 8'hA5, 1'b1},
    {2'd1, 8'hFF, 8'h00, 8'h05, 8'hFF, 8'hA5, 1'b0},
    {2'd1, 8'h00, 8'hFE, 8'h05, 8'hFF, 8'hA5, 1'b1},
    {2'd2, 8'h00, 8'hFF, 8'h05, 8'hFF, 8'h00, 1'b0},
    {2'd3, 8'h12, 8'hED, 8'h05, 8'hFF, 8'h00, 1'b0},
    {2'd3, 8'h12, 8'h12, 8'h05, 8'hFF, 8'h00, 1'b0},
    {2'd0, 8'h80, 8'h7F, 8'h80, 8'hFF, 8'h00, 1'b0},
    {2'd2, 8'h3C, 8'h3C, 8'h80, 8'hFF, 8'h00, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d, input logic [7:0] c, input logic [19:0] a, input bit ack);
    @(negedge clk);
    wr_stb = 1'b1; wr_sel = s; wr_data = d; wr_check = c; wr_addr = a; err_ack = ack;
    @(negedge clk);
    wr_stb = 1'b0; err_ack = 1'b0;
  endtask

  task automatic ack_err();
    @(negedge clk); err_ack = 1'b1;
    @(negedge clk); err_ack = 1'b0;
    chk(err_pend == 1'b0, "R6 ack clears pending", {31'd0, err_pend}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(stby_q == 8'h00, "R8 stby reset", stby_q, 8'h00);
    chk(wdog_q == 8'h70, "R8 wdog reset", wdog_q, 8'h70);
    chk(loc_q == 8'h0F, "R8 loc reset", loc_q, 8'h0F);
    chk(!err_req && !err_pend, "R8 error clear", {err_req, err_pend}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      logic [19:0] a;
      v = VEC[i];
      a = 20'h10000 + 20'(i * 3);
      wr(v[42:41], v[40:33], v[32:25], a, 1'b0);
      // R1 R2 R3 R7: all three registers after each strobe
      chk(stby_q == v[24:17], "R1/R2/R3/R7 stby", stby_q, v[24:17]);
      chk(wdog_q == v[16:9], "R1/R2/R3/R7 wdog", wdog_q, v[16:9]);
      chk(loc_q == v[8:1], "R1/R2/R3/R7 loc", loc_q, v[8:1]);
      chk(err_req == v[0], "R4 err_req after strobe", err_req, v[0]);
      if (v[0]) begin
        chk(err_addr == a, "R5 faulting start address", err_addr, a);
        @(negedge clk);
        chk(err_req == 1'b0 && err_pend, "R4 single-cycle pulse, pend held", {err_req, err_pend}, 2'b01);
        ack_err();
      end
    end

    // R5: a second fault while pending keeps the first address
    wr(2'd1, 8'h11, 8'h11, 20'hAAAAA, 1'b0);
    wr(2'd2, 8'h22, 8'h22, 20'hBBBBB, 1'b0);
    chk(err_req == 1'b1, "R4 second fault pulses", err_req, 1);
    chk(err_addr == 20'hAAAAA, "R5 first address kept", err_addr, 20'hAAAAA);
    repeat (3) @(negedge clk);
    chk(err_pend && err_addr == 20'hAAAAA, "R5 held until ack", err_addr, 20'hAAAAA);

    // R6: ack and a new fault in the same cycle
    wr(2'd0, 8'h44, 8'h45, 20'hCCCCC, 1'b1);
    chk(err_pend && err_addr == 20'hCCCCC, "R6 new fault on ack captured", err_addr, 20'hCCCCC);
    chk(stby_q == 8'h80, "R3 stby unchanged", stby_q, 8'h80);

    // R8: reset clears pending and restores values
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!err_pend && !err_req, "R8 reset clears pending", {err_req, err_pend}, 0);
    chk(stby_q == 8'h00 && wdog_q == 8'h70 && loc_q == 8'h0F, "R8 reset values",
        {8'h0, stby_q, wdog_q, loc_q}, 32'h0000700F);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule